// File: doc/BRIEF.md
# Dual-Mode Serial Port

A full-duplex serial port for a small controller. Software sees two byte-wide locations. The control location holds the mode, the receive options and the two completion flags. The data location is split by direction: a write loads the transmit shifter and starts sending at once, and a read returns the last byte received. Transmit and receive are independent, so both can run at the same time.

Two modes are available. In the clocked shift mode the block is the clock master. TXD carries a shift clock at one twelfth of the system clock, and RXD carries eight data bits, least significant bit first. RXD is driven outward when sending and sampled when receiving. In the asynchronous mode TXD sends and RXD receives 10-bit frames. Bit timing comes from an external baud tick, and one bit lasts 16 or 32 ticks. The receiver only stores a frame when the software has taken the previous byte. In multiprocessor mode it also needs the stop bit to be 1, which lets a node wait for address frames only.

Top module: `duplex_serial_port`

## Requirements
- R1: After reset the control byte reads 0, TXD is high and RXD is not driven. Control byte (address 0) layout: bit0 mode (1 = asynchronous), bit1 multiprocessor, bit2 receive enable, bit3 spare ninth transmit bit, bit4 copy of the received stop bit (writes ignored), bit5 TI, bit6 RI, bit7 double rate. Address 1 is the data buffer.
- R2: In shift mode, a data write sends the byte LSB first on RXD, with RXD driven (rxd_oe=1). Each bit is held for one shift-clock period of 12 system clocks, with TXD low for 6 clocks and then high for 6. Each bit is stable at the rising TXD edge. TI is set when the transfer completes.
- R3: In shift mode, with receive enable set and RI clear, the block clocks in 8 bits, LSB first. It samples RXD at the rising TXD edge, then loads the data buffer and sets RI.
- R4: In asynchronous mode, a data write sends a start bit of 0, the 8 data bits LSB first and a stop bit of 1 on TXD. TI is set after the stop bit.
- R5: An asynchronous bit lasts 16 baud ticks when the double-rate bit is 1 and 32 ticks when it is 0.
- R6: The asynchronous receiver detects a falling edge on RXD and confirms the start bit at its middle. It then samples each later bit at its centre. On a load it writes the byte to the buffer, copies the stop bit into control bit4 and sets RI.
- R7: A frame that ends while RI is 1 leaves the buffer, bit4 and RI unchanged.
- R8: With the multiprocessor bit set, a frame whose stop bit is 0 is discarded, and a frame whose stop bit is 1 is loaded.
- R9: With receive enable clear, an incoming frame changes neither the buffer nor RI.
- R10: A low pulse on RXD that has ended before the middle of the start bit puts the receiver back in idle without a load. The next real frame is still received correctly.
- R11: TI and RI stay set until software writes the control byte with those bits 0. A data write does not clear them.
- R12: A transmit and a receive can overlap in time. Reading address 1 returns the received byte, not the byte written for transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = control byte, 1 = data buffer |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for the location on addr |
| baud_tick | input | 1 | One-clock pulse from an external rate timer |
| rxd_i | input | 1 | RXD pin input |
| rxd_o | output | 1 | RXD pin output value (shift-mode transmit) |
| rxd_oe | output | 1 | RXD output enable |
| txd_o | output | 1 | TXD pin: shift clock or asynchronous data |

## Verification
Bit order, edge placement and the length of the start bit are measured at the pins. A swapped shift direction or a wrong divider would show up as a wrong byte or a wrong period. Each receive gate has its own test: RI already set, a zero stop bit under multiprocessor mode, receive disabled, and a short glitch. A design that drops any of these gates would overwrite the buffer, and the bench would see a changed byte or a set RI. The overlap test sends and receives at the same time on the shared data address, so an aliased buffer or a shared shifter would return the transmitted byte.

// File: rtl/sport_pkg.sv
`timescale 1ns/1ps
package sport_pkg;
  localparam int BIT_UART = 0;
  localparam int BIT_MP   = 1;
  localparam int BIT_REN  = 2;
  localparam int BIT_TB8  = 3;
  localparam int BIT_RB8  = 4;
  localparam int BIT_TI   = 5;
  localparam int BIT_RI   = 6;
  localparam int BIT_DBL  = 7;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  // Baud ticks per asynchronous bit.
  function automatic int unsigned bit_period(input logic dbl, input int unsigned fast);
    return dbl ? fast : 2 * fast;
  endfunction

  // Decide whether a finished asynchronous frame may be stored.
  function automatic logic rx_accept(input logic ri, input logic mp, input logic stop);
    return !ri && (!mp || stop);
  endfunction
endpackage

// File: rtl/sport_shift.sv
`timescale 1ns/1ps
module sport_shift #(
  parameter int DW  = 8,
  parameter int DIV = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_tx,
  input  logic [DW-1:0] tx_data,
  input  logic          start_rx,
  input  logic          rxd_i,
  output logic          busy,
  output logic          rxd_o,
  output logic          rxd_oe,
  output logic          sclk_o,
  output logic          tx_done,
  output logic          rx_done,
  output logic [DW-1:0] rx_data
);
  localparam int PW = $clog2(DIV);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  logic          dir_tx;
  logic [PW-1:0] ph;
  logic [BW-1:0] bc;
  logic [DW-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; dir_tx <= 1'b0; ph <= '0; bc <= '0; sr <= '0;
      tx_done <= 1'b0; rx_done <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      rx_done <= 1'b0;
      if (!busy) begin
        if (start_tx) begin
          busy <= 1'b1; dir_tx <= 1'b1; sr <= tx_data; ph <= '0; bc <= '0;
        end else if (start_rx) begin
          busy <= 1'b1; dir_tx <= 1'b0; ph <= '0; bc <= '0;
        end
      end else begin
        if (!dir_tx && ph == PW'(DIV / 2)) sr <= {rxd_i, sr[DW-1:1]};
        if (ph == PW'(DIV - 1)) begin
          ph <= '0;
          if (dir_tx) sr <= {1'b1, sr[DW-1:1]};
          if (bc == BW'(DW - 1)) begin
            busy    <= 1'b0;
            tx_done <= dir_tx;
            rx_done <= !dir_tx;
          end else begin
            bc <= bc + 1'b1;
          end
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  assign sclk_o  = !busy || (ph >= PW'(DIV / 2));
  assign rxd_oe  = busy && dir_tx;
  assign rxd_o   = rxd_oe ? sr[0] : 1'b1;
  assign rx_data = sr;
endmodule

// File: rtl/sport_uart_tx.sv
`timescale 1ns/1ps
module sport_uart_tx #(
  parameter int DW = 8,
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] data,
  input  logic          tick,
  input  logic [TW-1:0] period,
  output logic          busy,
  output logic          txd,
  output logic          done
);
  localparam int FW = $clog2(DW + 2);

  logic [DW+1:0] fr;
  logic [FW-1:0] n;
  logic [TW-1:0] tc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; fr <= '1; n <= '0; tc <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1; fr <= {1'b1, data, 1'b0}; n <= '0; tc <= '0;
      end else if (busy && tick) begin
        if (tc == period - 1'b1) begin
          tc <= '0;
          fr <= {1'b1, fr[DW+1:1]};
          if (n == FW'(DW + 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            n <= n + 1'b1;
          end
        end else begin
          tc <= tc + 1'b1;
        end
      end
    end
  end

  assign txd = busy ? fr[0] : 1'b1;
endmodule

// File: rtl/sport_uart_rx.sv
`timescale 1ns/1ps
module sport_uart_rx #(
  parameter int DW = 8,
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic [TW-1:0] period,
  input  logic          rxd_i,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          stop
);
  localparam int NW = (DW > 1) ? $clog2(DW) : 1;
  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_state_t;

  rx_state_t     st;
  logic          s1, s2, s3;
  logic [TW-1:0] tc;
  logic [NW-1:0] n;
  logic [TW-1:0] half;
  logic          fall;

  assign half = period >> 1;
  assign fall = s3 && !s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
      st <= S_IDLE; tc <= '0; n <= '0; data <= '0; stop <= 1'b0; done <= 1'b0;
    end else begin
      s1 <= rxd_i; s2 <= s1; s3 <= s2;
      done <= 1'b0;
      if (!en) begin
        st <= S_IDLE;
      end else begin
        unique case (st)
          S_IDLE: if (fall) begin st <= S_START; tc <= '0; end
          S_START: if (tick) begin
            if (tc == half - 1'b1) begin
              tc <= '0; n <= '0;
              st <= s2 ? S_IDLE : S_DATA;
            end else tc <= tc + 1'b1;
          end
          S_DATA: if (tick) begin
            if (tc == period - 1'b1) begin
              tc   <= '0;
              data <= {s2, data[DW-1:1]};
              if (n == NW'(DW - 1)) st <= S_STOP;
              else n <= n + 1'b1;
            end else tc <= tc + 1'b1;
          end
          S_STOP: if (tick) begin
            if (tc == period - 1'b1) begin
              stop <= s2; done <= 1'b1; st <= S_IDLE; tc <= '0;
            end else tc <= tc + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/duplex_serial_port.sv
`timescale 1ns/1ps
module duplex_serial_port #(
  parameter int DW         = 8,
  parameter int FAST_TICKS = 16,
  parameter int SHIFT_DIV  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          baud_tick,
  input  logic          rxd_i,
  output logic          rxd_o,
  output logic          rxd_oe,
  output logic          txd_o
);
  import sport_pkg::*;
  localparam int TW = $clog2(2 * FAST_TICKS) + 1;

  logic r_uart, r_mp, r_ren, r_tb8, r_rb8, r_ti, r_ri, r_dbl;
  logic [DW-1:0] rx_buf;
  logic [TW-1:0] period;

  logic wr_ctrl, wr_data;
  logic shift_busy, shift_tx_done, shift_rx_done, sclk, shift_start_rx;
  logic [DW-1:0] shift_rx_data;
  logic utx_busy, utx_txd, utx_done;
  logic ur_done, ur_stop;
  logic [DW-1:0] ur_data;
  logic rx_load_shift, rx_load_uart, rx_load, tx_done_any;
  logic [7:0] ctrl_byte;

  assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
  assign wr_data = wr_en && (addr == ADDR_DATA);
  assign period  = TW'(bit_period(r_dbl, FAST_TICKS));

  assign shift_start_rx = !r_uart && r_ren && !r_ri && !wr_data && !shift_rx_done;

  sport_shift #(.DW(DW), .DIV(SHIFT_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .start_tx(wr_data && !r_uart), .tx_data(wdata),
    .start_rx(shift_start_rx), .rxd_i(rxd_i),
    .busy(shift_busy), .rxd_o(rxd_o), .rxd_oe(rxd_oe), .sclk_o(sclk),
    .tx_done(shift_tx_done), .rx_done(shift_rx_done), .rx_data(shift_rx_data)
  );

  sport_uart_tx #(.DW(DW), .TW(TW)) u_utx (
    .clk(clk), .rst_n(rst_n), .start(wr_data && r_uart), .data(wdata),
    .tick(baud_tick), .period(period),
    .busy(utx_busy), .txd(utx_txd), .done(utx_done)
  );

  sport_uart_rx #(.DW(DW), .TW(TW)) u_urx (
    .clk(clk), .rst_n(rst_n), .en(r_uart && r_ren), .tick(baud_tick),
    .period(period), .rxd_i(rxd_i),
    .done(ur_done), .data(ur_data), .stop(ur_stop)
  );

  assign rx_load_shift = shift_rx_done && !r_ri;
  assign rx_load_uart  = ur_done && rx_accept(r_ri, r_mp, ur_stop);
  assign rx_load       = rx_load_shift || rx_load_uart;
  assign tx_done_any   = shift_tx_done || utx_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_uart <= 1'b0; r_mp <= 1'b0; r_ren <= 1'b0; r_tb8 <= 1'b0;
      r_rb8 <= 1'b0; r_ti <= 1'b0; r_ri <= 1'b0; r_dbl <= 1'b0;
      rx_buf <= '0;
    end else begin
      if (wr_ctrl) begin
        r_uart <= wdata[BIT_UART];
        r_mp   <= wdata[BIT_MP];
        r_ren  <= wdata[BIT_REN];
        r_tb8  <= wdata[BIT_TB8];
        r_dbl  <= wdata[BIT_DBL];
        r_ti   <= wdata[BIT_TI] || tx_done_any;
        r_ri   <= wdata[BIT_RI] || rx_load;
      end else begin
        if (tx_done_any) r_ti <= 1'b1;
        if (rx_load)     r_ri <= 1'b1;
      end
      if (rx_load_shift) rx_buf <= shift_rx_data;
      if (rx_load_uart) begin
        rx_buf <= ur_data;
        r_rb8  <= ur_stop;
      end
    end
  end

  assign ctrl_byte = {r_dbl, r_ri, r_ti, r_rb8, r_tb8, r_ren, r_mp, r_uart};
  assign rdata     = (addr == ADDR_DATA) ? rx_buf : DW'(ctrl_byte);
  assign txd_o     = shift_busy ? sclk : utx_txd;
endmodule

// File: rtl/sport_checker.sv
`timescale 1ns/1ps
module sport_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          shift_busy,
  input logic          utx_busy,
  input logic          txd_o,
  input logic          wr_ctrl,
  input logic          r_ti,
  input logic          r_ri,
  input logic          r_mp,
  input logic          r_uart,
  input logic          r_ren,
  input logic          r_rb8,
  input logic          rx_load,
  input logic          ur_done,
  input logic [DW-1:0] rx_buf
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_busy && !utx_busy) |-> txd_o);

  assert_ti_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (r_ti && !wr_ctrl) |=> r_ti);

  assert_ri_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (r_ri && !wr_ctrl) |=> r_ri);

  assert_buf_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    r_ri |=> $stable(rx_buf));

  assert_load_sets_ri_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> r_ri);

  assert_mp_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && r_uart && r_mp) |=> r_rb8);

  assert_ren_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_ren && !$past(r_ren)) |-> !ur_done);
endmodule

bind duplex_serial_port sport_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_busy(shift_busy), .utx_busy(utx_busy),
  .txd_o(txd_o), .wr_ctrl(wr_ctrl), .r_ti(r_ti), .r_ri(r_ri), .r_mp(r_mp),
  .r_uart(r_uart), .r_ren(r_ren), .r_rb8(r_rb8), .rx_load(rx_load),
  .ur_done(ur_done), .rx_buf(rx_buf)
);

// File: tb/tb_duplex_serial_port.sv
`timescale 1ns/1ps
module tb_duplex_serial_port;
  localparam int FAST = 16;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, addr = 1'b0;
  logic baud_tick = 1'b0, rxd_i = 1'b1;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic rxd_o, rxd_oe, txd_o;
  int vectors = 0, miscompares = 0, tick_div = 1, tcnt = 0;

  duplex_serial_port dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .baud_tick(baud_tick), .rxd_i(rxd_i), .rxd_o(rxd_o),
    .rxd_oe(rxd_oe), .txd_o(txd_o)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (tcnt >= tick_div - 1) begin baud_tick <= 1'b1; tcnt <= 0; end
    else begin baud_tick <= 1'b0; tcnt <= tcnt + 1; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_reg(input logic a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wait_ctrl(input int b, input int maxc, output bit seen);
    logic [7:0] v;
    seen = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk); read_reg(1'b0, v);
      if (v[b]) begin seen = 1; break; end
    end
  endtask

  function automatic int bitc(input bit dbl);
    return (dbl ? FAST : 2 * FAST) * tick_div;
  endfunction

  task automatic send_frame(input logic [7:0] d, input logic stop, input int bc);
    rxd_i = 1'b0; repeat (bc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd_i = d[i]; repeat (bc) @(negedge clk); end
    rxd_i = stop; repeat (bc) @(negedge clk);
    rxd_i = 1'b1; repeat (bc) @(negedge clk);
  endtask

  task automatic uart_capture(input int bc, output logic [9:0] fr, output bit ok);
    ok = 0; fr = '0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!txd_o) begin ok = 1; break; end
    end
    if (ok) begin
      repeat (bc / 2) @(negedge clk);
      fr[0] = txd_o;
      for (int i = 1; i < 10; i++) begin repeat (bc) @(negedge clk); fr[i] = txd_o; end
    end
  endtask

  task automatic measure_low(output int n);
    n = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!txd_o) break;
    end
    while (!txd_o && n < 4000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    @(negedge clk); read_reg(1'b0, v);
    chk("R1 control byte after reset", v, 8'h00);
    chk("R1 txd idle high", txd_o, 1'b1);
    chk("R1 rxd not driven", rxd_oe, 1'b0);
    read_reg(1'b1, v);
    chk("R1 data buffer after reset", v, 8'h00);
  endtask

  task automatic t_shift_tx();
    logic [7:0] got = '0, v;
    int rises = 0, first = 0, second = 0, cyc = 0;
    logic prev = 1'b1, oe_ok = 1'b1;
    bit seen;
    write_reg(1'b0, 8'h00);
    write_reg(1'b1, 8'hA5);
    while (rises < 8 && cyc < 400) begin
      if (!prev && txd_o) begin
        got[rises] = rxd_o; oe_ok &= rxd_oe;
        if (rises == 0) first = cyc;
        if (rises == 1) second = cyc;
        rises++;
      end
      prev = txd_o; @(negedge clk); cyc++;
    end
    chk("R2 shifted byte lsb first", got, 8'hA5);
    chk("R2 shift clock period", second - first, 12);
    chk("R2 rxd driven while sending", oe_ok, 1'b1);
    wait_ctrl(5, 100, seen);
    chk("R2 TI after shift transfer", seen, 1'b1);
    write_reg(1'b0, 8'h00);
    read_reg(1'b0, v);
    chk("R11 TI cleared by control write", v[5], 1'b0);
  endtask

  task automatic t_shift_rx();
    logic [7:0] b = 8'h3C, v;
    bit seen;
    rxd_i = b[0];
    write_reg(1'b0, 8'h04);
    @(negedge txd_o);
    for (int i = 1; i < 8; i++) begin @(negedge txd_o); rxd_i = b[i]; end
    wait_ctrl(6, 200, seen);
    chk("R3 RI after shift receive", seen, 1'b1);
    read_reg(1'b1, v);
    chk("R3 shift received byte", v, 8'h3C);
    rxd_i = 1'b1;
    write_reg(1'b0, 8'h01);
  endtask

  task automatic t_uart_tx(input bit dbl, input logic [7:0] d);
    logic [9:0] fr; bit ok, seen; int low, bc;
    tick_div = 1;
    write_reg(1'b0, dbl ? 8'h81 : 8'h01);
    bc = bitc(dbl);
    fork
      write_reg(1'b1, d);
      uart_capture(bc, fr, ok);
      measure_low(low);
    join
    chk("R4 frame start seen", ok, 1'b1);
    chk("R4 transmitted frame", fr, {1'b1, d, 1'b0});
    chk("R5 start bit length in ticks", low, dbl ? 16 : 32);
    wait_ctrl(5, 3 * bc, seen);
    chk("R4 TI after stop bit", seen, 1'b1);
    write_reg(1'b0, dbl ? 8'h81 : 8'h01);
  endtask

  task automatic t_uart_rx();
    logic [7:0] v;
    tick_div = 2;
    write_reg(1'b0, 8'h85);
    send_frame(8'h9A, 1'b1, bitc(1));
    read_reg(1'b1, v); chk("R6 received byte", v, 8'h9A);
    read_reg(1'b0, v);
    chk("R6 RI set", v[6], 1'b1);
    chk("R6 stop copied to bit4", v[4], 1'b1);
    send_frame(8'h11, 1'b1, bitc(1));
    read_reg(1'b1, v); chk("R7 buffer kept while RI set", v, 8'h9A);
    write_reg(1'b0, 8'h85);
    send_frame(8'h66, 1'b0, bitc(1));
    read_reg(1'b1, v); chk("R6 byte with zero stop, mp off", v, 8'h66);
    read_reg(1'b0, v); chk("R6 bit4 copies zero stop", v[4], 1'b0);
  endtask

  task automatic t_mp();
    logic [7:0] v;
    write_reg(1'b0, 8'h87);
    send_frame(8'h22, 1'b0, bitc(1));
    read_reg(1'b1, v); chk("R8 zero stop discarded", v, 8'h66);
    read_reg(1'b0, v); chk("R8 RI clear after discard", v[6], 1'b0);
    send_frame(8'h44, 1'b1, bitc(1));
    read_reg(1'b1, v); chk("R8 stop one loaded", v, 8'h44);
    read_reg(1'b0, v); chk("R8 RI and bit4 set", {v[6], v[4]}, 2'b11);
  endtask

  task automatic t_ren_off();
    logic [7:0] v;
    write_reg(1'b0, 8'h81);
    send_frame(8'h77, 1'b1, bitc(1));
    read_reg(1'b1, v); chk("R9 buffer unchanged with receive off", v, 8'h44);
    read_reg(1'b0, v); chk("R9 RI unchanged with receive off", v[6], 1'b0);
  endtask

  task automatic t_false_start();
    logic [7:0] v;
    write_reg(1'b0, 8'h85);
    rxd_i = 1'b0; repeat (3 * tick_div) @(negedge clk);
    rxd_i = 1'b1; repeat (2 * bitc(1)) @(negedge clk);
    read_reg(1'b0, v); chk("R10 glitch gives no RI", v[6], 1'b0);
    read_reg(1'b1, v); chk("R10 glitch leaves buffer", v, 8'h44);
    send_frame(8'h5E, 1'b1, bitc(1));
    read_reg(1'b1, v); chk("R10 frame after glitch", v, 8'h5E);
  endtask

  task automatic t_sticky();
    logic [7:0] v;
    write_reg(1'b1, 8'h0F);
    repeat (50) @(negedge clk);
    read_reg(1'b0, v); chk("R11 RI survives data write", v[6], 1'b1);
    repeat (400) @(negedge clk);
    read_reg(1'b0, v); chk("R11 TI set and RI still set", {v[6], v[5]}, 2'b11);
    write_reg(1'b0, 8'h85);
    read_reg(1'b0, v); chk("R11 flags cleared by control write", {v[6], v[5]}, 2'b00);
  endtask

  task automatic t_duplex();
    logic [9:0] fr; bit ok; logic [7:0] v;
    fork
      write_reg(1'b1, 8'h18);
      uart_capture(bitc(1), fr, ok);
      send_frame(8'hE7, 1'b1, bitc(1));
    join
    chk("R12 transmit during receive", fr, {1'b1, 8'h18, 1'b0});
    read_reg(1'b1, v); chk("R12 read returns received byte", v, 8'hE7);
    read_reg(1'b0, v); chk("R12 RI after overlapped receive", v[6], 1'b1);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_shift_tx();
    t_shift_rx();
    t_uart_tx(1'b0, 8'h55);
    t_uart_tx(1'b1, 8'hC3);
    t_uart_rx();
    t_mp();
    t_ren_off();
    t_false_start();
    t_sticky();
    t_duplex();
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: all requirements actual=timeout expected=completion");
    report();
    $finish;
  end
endmodule